// File: doc/BRIEF.md
# Pixel Color-Match Event Trigger

This block sits on a 24-bit RGB pixel bus that delivers one pixel on each rising edge of the pixel clock, which runs at roughly 12 to 22 MHz. Each pixel is compared against a color rule table that is fixed when the block is elaborated. Each rule names one exact color, one event output and an action. The event outputs are registered on the pixel clock, so they carry no glitches while the bus settles, and a single matching pixel produces an event that lasts one full clock.

Each event output has one of three modes. A pulse output shows a 1 in the cycle after a matching pixel. An inverted pulse output shows a 0 in that cycle. A latch output is set by its set colors, cleared by its clear colors and holds on every other pixel. The block also registers the pixel and the active-video flag and passes them out with the same one-clock delay, so downstream logic sees each event lined up with the pixel that caused it. During blanking no rule can fire. A full-size table of about 50 to 100 rules driving about 20 outputs is made by overriding the parameters.

Top module: `pixmatch_trigger`

## Requirements
- R1: A rule matches only when all three 8-bit channels of the pixel equal the rule color. A pixel that differs from the color by a single bit in any one channel does not match.
- R2: Several rules may drive the same output. Any one of a pulse output's colors fires it, and any one of a latch output's set colors (or clear colors) sets it (or clears it).
- R3: A pulse-mode output (mode code 0) is 1 in the cycle after an active pixel that matches one of its colors, and 0 after any other pixel. A single matching pixel gives a pulse exactly one clock wide.
- R4: An inverted pulse-mode output (mode code 1) is 0 in the cycle after an active matching pixel, and 1 after any other pixel.
- R5: A latch-mode output (mode code 2) becomes 1 after an active pixel that matches a set rule (action code 1). It becomes 0 after an active pixel that matches a clear rule (action code 2). After any other pixel it keeps its value.
- R6: The pixel output equals the pixel input of the previous clock.
- R7: The active-video output equals the active-video input of the previous clock.
- R8: After a pixel with active-video low, no rule has effect. Pulse outputs show 0, inverted pulse outputs show 1, and latch outputs keep their value.
- R9: A synchronous active-high reset makes the pixel output 0, the active-video output 0, pulse and latch outputs 0, and inverted pulse outputs 1, starting from the next clock.
- R10: If a color appears in more than one set or clear rule for the same latch output, the rule with the lowest index decides the action.
- R11: The default table has 4 outputs with modes pulse, inverted pulse, latch and latch (outputs 0 to 3). It has 10 rules, by index: 0: 908858 hit out0; 1: 00FF00 hit out0; 2: 808080 hit out1; 3: 0000FF set out2; 4: FF0000 set out2; 5: 00FFFF clear out2; 6: 00C400 clear out2; 7: 123456 set out3; 8: 123456 clear out3; 9: 654321 clear out3. Action code 0 is hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pixIn | input | 24 | Incoming pixel, three 8-bit channels |
| activeIn | input | 1 | High while the pixel is part of the visible image |
| pixOut | output | 24 | Pixel delayed by one clock |
| activeOut | output | 1 | Active-video flag delayed by one clock |
| eventOut | output | NUM_OUT (4) | Registered event outputs, one per output index |

## Verification
The assertions assume that reset is driven to a known level from the first clock edge. They also assume that pixIn and activeIn are stable around each rising edge, since they compare the outputs only against inputs sampled on the previous edge. The bench holds reset high from time zero and changes every input only on the falling clock edge. Its stimulus includes blanking runs that carry table colors, so that the properties about holding and gating during blanking are exercised with colors that would otherwise match.

// File: rtl/pixmatch_pkg.sv
package pixmatch_pkg;

  localparam int CHAN_W = 8;
  localparam int NUM_CHAN = 3;
  localparam int PIX_W = CHAN_W * NUM_CHAN;

  // what a rule does to its output (only set/clear matter for latches)
  typedef enum logic [1:0] {
    ACT_HIT = 2'd0,
    ACT_SET = 2'd1,
    ACT_CLR = 2'd2
  } rule_act_e;

  // behaviour of one event output
  typedef enum logic [1:0] {
    MODE_PULSE     = 2'd0,
    MODE_PULSE_INV = 2'd1,
    MODE_LATCH     = 2'd2
  } out_mode_e;

  // per-output strobes from control to datapath
  typedef struct packed {
    logic hit;
    logic set;
    logic clr;
  } strobe_t;

endpackage

// File: rtl/pixmatch_ctrl.sv
module pixmatch_ctrl
  import pixmatch_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_RULES = 10,
  localparam int OUT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  parameter logic [NUM_RULES*PIX_W-1:0] RULE_COLOR = '0,
  parameter logic [NUM_RULES*OUT_W-1:0] RULE_OUT = '0,
  parameter logic [NUM_RULES*2-1:0] RULE_ACT = '0
) (
  input  logic [PIX_W-1:0] pixIn,
  input  logic             activeIn,
  output strobe_t          strobes [NUM_OUT]
);

  logic [NUM_RULES-1:0] ruleHit;

  // one comparator per rule: AND of the per-channel equalities
  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    logic [NUM_CHAN-1:0] chanEq;
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      assign chanEq[c] = (pixIn[c*CHAN_W +: CHAN_W] ==
                          RULE_COLOR[r*PIX_W + c*CHAN_W +: CHAN_W]);
    end
    assign ruleHit[r] = activeIn & (&chanEq);
  end

  // walk from the last rule to the first so the lowest index decides
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      strobes[o] = '0;
      for (int r = NUM_RULES - 1; r >= 0; r--) begin
        if (ruleHit[r] && (RULE_OUT[r*OUT_W +: OUT_W] == OUT_W'(o))) begin
          strobes[o].hit = 1'b1;
          if (RULE_ACT[r*2 +: 2] == 2'(ACT_SET)) begin
            strobes[o].set = 1'b1;
            strobes[o].clr = 1'b0;
          end else if (RULE_ACT[r*2 +: 2] == 2'(ACT_CLR)) begin
            strobes[o].set = 1'b0;
            strobes[o].clr = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pixmatch_dp.sv
module pixmatch_dp
  import pixmatch_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT*2-1:0] OUT_MODE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic               activeIn,
  input  strobe_t            strobes [NUM_OUT],
  output logic [PIX_W-1:0]   pixOut,
  output logic               activeOut,
  output logic [NUM_OUT-1:0] eventOut
);

  // pass-through stage, same latency as the events
  always_ff @(posedge clk) begin
    if (rst) begin
      pixOut    <= '0;
      activeOut <= 1'b0;
    end else begin
      pixOut    <= pixIn;
      activeOut <= activeIn;
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam logic [1:0] MODE = OUT_MODE[o*2 +: 2];
    if (MODE == 2'(MODE_LATCH)) begin : g_latch
      always_ff @(posedge clk) begin
        if (rst)                 eventOut[o] <= 1'b0;
        else if (strobes[o].set) eventOut[o] <= 1'b1;
        else if (strobes[o].clr) eventOut[o] <= 1'b0;
      end
    end else if (MODE == 2'(MODE_PULSE_INV)) begin : g_inv
      always_ff @(posedge clk) begin
        if (rst) eventOut[o] <= 1'b1;
        else     eventOut[o] <= ~strobes[o].hit;
      end
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) eventOut[o] <= 1'b0;
        else     eventOut[o] <= strobes[o].hit;
      end
    end
  end

endmodule

// File: rtl/pixmatch_trigger.sv
module pixmatch_trigger
  import pixmatch_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_RULES = 10,
  localparam int OUT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  parameter logic [NUM_RULES*PIX_W-1:0] RULE_COLOR = {
    24'h654321, 24'h123456, 24'h123456, 24'h00C400, 24'h00FFFF,
    24'hFF0000, 24'h0000FF, 24'h808080, 24'h00FF00, 24'h908858},
  parameter logic [NUM_RULES*OUT_W-1:0] RULE_OUT = {
    2'd3, 2'd3, 2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0},
  parameter logic [NUM_RULES*2-1:0] RULE_ACT = {
    2'd2, 2'd2, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0},
  parameter logic [NUM_OUT*2-1:0] OUT_MODE = {2'd2, 2'd2, 2'd1, 2'd0}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [23:0]        pixIn,
  input  logic               activeIn,
  output logic [23:0]        pixOut,
  output logic               activeOut,
  output logic [NUM_OUT-1:0] eventOut
);

  strobe_t strobes [NUM_OUT];

  pixmatch_ctrl #(
    .NUM_OUT(NUM_OUT), .NUM_RULES(NUM_RULES),
    .RULE_COLOR(RULE_COLOR), .RULE_OUT(RULE_OUT), .RULE_ACT(RULE_ACT)
  ) u_ctrl (
    .pixIn(pixIn), .activeIn(activeIn), .strobes(strobes)
  );

  pixmatch_dp #(
    .NUM_OUT(NUM_OUT), .OUT_MODE(OUT_MODE)
  ) u_dp (
    .clk(clk), .rst(rst), .pixIn(pixIn), .activeIn(activeIn),
    .strobes(strobes), .pixOut(pixOut), .activeOut(activeOut),
    .eventOut(eventOut)
  );

endmodule

// File: rtl/pixmatch_trigger_chk.sv
module pixmatch_trigger_chk #(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT*2-1:0] OUT_MODE = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [23:0]        pixIn,
  input logic               activeIn,
  input logic [23:0]        pixOut,
  input logic               activeOut,
  input logic [NUM_OUT-1:0] eventOut
);

  function automatic logic [NUM_OUT-1:0] modeMask(input logic [1:0] m);
    logic [NUM_OUT-1:0] v;
    v = '0;
    for (int o = 0; o < NUM_OUT; o++) v[o] = (OUT_MODE[o*2 +: 2] == m);
    return v;
  endfunction

  localparam logic [NUM_OUT-1:0] INV_MASK   = modeMask(2'd1);
  localparam logic [NUM_OUT-1:0] LATCH_MASK = modeMask(2'd2);

  // R6
  pix_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pixOut == $past(pixIn));

  // R7
  active_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> activeOut == $past(activeIn));

  // R8
  blank_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !activeIn |=> (eventOut & ~LATCH_MASK) == INV_MASK);

  // R8
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !activeIn |=> (eventOut & LATCH_MASK) == ($past(eventOut) & LATCH_MASK));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pixOut == '0) && !activeOut && (eventOut == INV_MASK));

endmodule

bind pixmatch_trigger pixmatch_trigger_chk #(
  .NUM_OUT(NUM_OUT), .OUT_MODE(OUT_MODE)
) chk (.*);

// File: tb/pixmatch_trigger_test.sv
module pixmatch_trigger_test;

  localparam int CLK_PERIOD = 50;
  localparam int NUM_OUT = 4;
  localparam int NUM_RULES = 10;

  // default table as given in R11
  int unsigned colorTab [NUM_RULES] = '{24'h908858, 24'h00FF00, 24'h808080,
    24'h0000FF, 24'hFF0000, 24'h00FFFF, 24'h00C400, 24'h123456, 24'h123456,
    24'h654321};
  int outTab [NUM_RULES] = '{0, 0, 1, 2, 2, 2, 2, 3, 3, 3};
  int actTab [NUM_RULES] = '{0, 0, 0, 1, 1, 2, 2, 1, 2, 2};
  int modeTab [NUM_OUT] = '{0, 1, 2, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] pixIn = '0;
  logic activeIn = 1'b0;
  logic [23:0] pixOut;
  logic activeOut;
  logic [NUM_OUT-1:0] eventOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [23:0] expPix;
  logic expAct;
  logic [NUM_OUT-1:0] expEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixmatch_trigger uut (
    .clk(clk), .rst(rst), .pixIn(pixIn), .activeIn(activeIn),
    .pixOut(pixOut), .activeOut(activeOut), .eventOut(eventOut)
  );

  task automatic check(string req, string tag, string what,
                       logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s (%s) %s: actual=%h expected=%h", req, tag, what, got, exp);
    end
  endtask

  // drive one pixel, update the model at the edge, compare half a clock later
  task automatic drive(logic [23:0] p, logic a, string tag);
    pixIn = p;
    activeIn = a;
    @(posedge clk);
    if (rst) begin
      expPix = '0;
      expAct = 1'b0;
      for (int o = 0; o < NUM_OUT; o++) expEv[o] = (modeTab[o] == 1);
    end else begin
      expPix = p;
      expAct = a;
      for (int o = 0; o < NUM_OUT; o++) begin
        bit hit = 0;
        int first = -1;
        for (int r = 0; r < NUM_RULES; r++) begin
          if (a && outTab[r] == o && colorTab[r] == 32'(p)) begin
            hit = 1;
            if (first < 0 && actTab[r] != 0) first = r;
          end
        end
        if (modeTab[o] == 0) expEv[o] = hit;
        else if (modeTab[o] == 1) expEv[o] = !hit;
        else if (first >= 0) expEv[o] = (actTab[first] == 1);
      end
    end
    @(negedge clk);
    if (rst) begin
      check("R9", tag, "pixOut", 32'(pixOut), 32'(expPix));
      check("R9", tag, "activeOut", 32'(activeOut), 32'(expAct));
      check("R9", tag, "eventOut", 32'(eventOut), 32'(expEv));
    end else begin
      check("R6", tag, "pixOut", 32'(pixOut), 32'(expPix));
      check("R7", tag, "activeOut", 32'(activeOut), 32'(expAct));
      for (int o = 0; o < NUM_OUT; o++) begin
        string req;
        if (!a) req = "R8";
        else if (modeTab[o] == 0) req = "R3";
        else if (modeTab[o] == 1) req = "R4";
        else req = "R5";
        check(req, tag, $sformatf("eventOut[%0d]", o),
              32'(eventOut[o]), 32'(expEv[o]));
      end
    end
  endtask

  initial begin
    // R9 reset state
    drive(24'h908858, 1'b1, "R9 reset");
    drive(24'h0000FF, 1'b1, "R9 reset");
    rst = 1'b0;
    // R3 single pixel pulse, R4 inverted
    drive(24'h908858, 1'b1, "R3 one pixel");
    drive(24'h000000, 1'b1, "R3 pulse ends");
    drive(24'h00FF00, 1'b1, "R2 second pulse color");
    drive(24'h00FF00, 1'b1, "R3 repeated match");
    drive(24'h808080, 1'b1, "R4 inverted match");
    drive(24'h808081, 1'b1, "R4 inverted idle");
    // R1 one-bit misses in each channel
    drive(24'h908859, 1'b1, "R1 low channel");
    drive(24'h908958, 1'b1, "R1 mid channel");
    drive(24'h918858, 1'b1, "R1 high channel");
    drive(24'h0001FF, 1'b1, "R1 near set color");
    // R5 latch set, hold, clear
    drive(24'h0000FF, 1'b1, "R5 set");
    drive(24'h111111, 1'b1, "R5 hold");
    drive(24'h00FFFF, 1'b1, "R5 clear");
    drive(24'h222222, 1'b1, "R5 hold low");
    drive(24'hFF0000, 1'b1, "R2 second set color");
    drive(24'h00C400, 1'b1, "R2 second clear color");
    // R8 blanking
    drive(24'h0000FF, 1'b0, "R8 set ignored");
    drive(24'h908858, 1'b0, "R8 pulse suppressed");
    drive(24'h808080, 1'b0, "R8 inverted held high");
    drive(24'h0000FF, 1'b1, "R5 set again");
    drive(24'h00FFFF, 1'b0, "R8 clear ignored");
    drive(24'h333333, 1'b1, "R8 still set after blank");
    // R10 duplicate color, first rule wins
    drive(24'h123456, 1'b1, "R10 duplicate sets");
    drive(24'h654321, 1'b1, "R10 other clear");
    drive(24'h123456, 1'b1, "R10 duplicate sets again");
    // R9 mid-run reset
    rst = 1'b1;
    drive(24'h0000FF, 1'b1, "R9 mid-run reset");
    rst = 1'b0;
    drive(24'h123456, 1'b1, "R10 after reset");
    // random mix of table colors, near misses and blanking
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] p;
      logic a;
      int sel = $urandom_range(0, 3);
      a = ((i % 64) < 48);
      if (sel == 0) p = 24'($urandom);
      else p = 24'(colorTab[$urandom_range(0, NUM_RULES - 1)]);
      if (sel == 1) p[$urandom_range(0, 23)] ^= 1'b1;
      drive(p, a, "R2 R6 R7 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL all (watchdog): actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule